// File: doc/BRIEF.md
# Chained DMA Descriptor Engine

A single-channel engine that walks a linked list of command descriptors stored in word-addressed memory. Software loads the byte address of the first descriptor, then adds a count to a semaphore. While the semaphore is nonzero and a start address has been supplied, the engine fetches a descriptor, issues its peripheral register writes, moves its payload in the direction the command code selects, and either follows the next pointer or stops.

Each descriptor occupies consecutive 32-bit words at its base address B. The word at B is the next-descriptor address. The word at B+4 carries the control half-word in bits 15:0 and the byte count in bits 31:16. The word at B+8 is the buffer address. Up to fifteen register-write words follow from B+12. The engine moves data one 32-bit word at a time, so a byte count N gives ceil(N/4) words. All memory traffic uses one request/acknowledge port with one access outstanding.

A descriptor whose next pointer leads back to an earlier descriptor forms a ring. With a ring, the semaphore paces a cyclic transfer: each descriptor that decrements it consumes one credit, and the ring resumes from the following descriptor when more credit is added.

Top module: `desc_chain_engine`

## Requirements
- R1: After reset the engine is idle (`busy`=0), the semaphore reads 0, the buffer address reads 0, and no request, strobe or pulse is asserted.
- R2: A write to `sem_add_we` adds `sem_add_val` to the semaphore. A transfer starts only when a start address has been written and the semaphore is nonzero.
- R3: The control half-word is decoded as follows: command in bits 1:0, chain in bit 2, interrupt in bit 3, semaphore decrement in bit 6, register-write count n in bits 15:12. Before any data moves, the words at B+12, B+16, and so on up to B+8+4n are written in order to peripheral indices 0 to n-1.
- R4: Command 2 reads ceil(N/4) words from memory, starting at the buffer address and counting upward. Each word goes out on `dev_wdata` with one `dev_wr` strobe.
- R5: Command 1 takes one word from `dev_rdata` per `dev_rd` strobe and writes it to memory at the buffer address, which steps up by 4 for each word.
- R6: Command 0, command 3 and a byte count of 0 move no data. The buffer address stays at the value loaded from the descriptor.
- R7: When a descriptor with the decrement bit completes, the semaphore drops by one. If it reaches zero, the engine goes idle after that descriptor.
- R8: With the chain bit set, the next descriptor is fetched from the next-address word. If the engine went idle because the semaphore ran out, `cur_desc` already holds that next address, and adding credit resumes from it.
- R9: A descriptor without the chain bit ends the run. Adding credit alone does not restart the engine; a new start address must be written.
- R10: A descriptor with the interrupt bit raises `cmpl_pulse` for one cycle, after its data phase and not before.
- R11: An error response on a memory access aborts the run. It raises `err_pulse` with `err_code`=2'b10 (bus error) and no completion pulse, and it leaves the semaphore unchanged. A new start address is then required.
- R12: While `freeze` is high, no new memory request is started and no `pio_we`, `dev_wr` or `dev_rd` strobe is issued. The run resumes without loss when `freeze` falls.
- R13: `buf_addr` shows the address of the current data word, so the residue can be computed by subtraction. At the end of a descriptor it equals the buffer address plus 4·ceil(N/4). A byte count of 0xFF00 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_addr_we | input | 1 | Load start descriptor address (accepted while idle) |
| desc_addr_wdata | input | AW | Start descriptor byte address |
| sem_add_we | input | 1 | Add to semaphore |
| sem_add_val | input | SEM_W | Credit to add |
| freeze | input | 1 | Hold the channel between beats |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| pio_we | output | 1 | Peripheral register write strobe |
| pio_idx | output | 4 | Peripheral register index |
| pio_wdata | output | 32 | Peripheral register data |
| dev_wr | output | 1 | Word delivered to device |
| dev_wdata | output | 32 | Data to device |
| dev_rd | output | 1 | Word taken from device |
| dev_rdata | input | 32 | Data from device |
| cmpl_pulse | output | 1 | Descriptor completion pulse |
| err_pulse | output | 1 | Abort pulse |
| err_code | output | 2 | Error kind, 2'b10 = bus error |
| busy | output | 1 | Channel running |
| sem_count | output | SEM_W | Semaphore value |
| buf_addr | output | AW | Current transfer address |
| cur_desc | output | AW | Address of current or next descriptor |

## Verification
The bench drives single descriptors in each direction and chains that mix device-to-memory data with register-only descriptors. These show whether the field decode and the order of fetch, register writes and data phase are right. A two-descriptor ring paced by credit separates "stop at zero credit and resume at the next pointer" from "stop at an unchained end". Descriptors with a zero byte count and with the sense code check that no data moves. A freeze held across the middle of a data phase, an error-region buffer address, and a 0xFF00-byte transfer cover holding state, aborting, and the largest count. The data of every transfer is traced through `buf_addr`.

// File: rtl/dce_pkg.sv
package dce_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 16;
  localparam int PIO_W  = 4;
  localparam logic [1:0] ERR_BUS = 2'b10;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_DEV2MEM = 2'd1,
    CMD_MEM2DEV = 2'd2,
    CMD_SENSE   = 2'd3
  } xfer_cmd_e;

  typedef struct packed {
    logic [PIO_W-1:0] pio_n;
    logic             dec_sem;
    logic             irq;
    logic             chain;
    xfer_cmd_e        cmd;
  } ctl_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_NEXT, ST_CTRL, ST_BUF, ST_PRD, ST_PWR,
    ST_DRD, ST_DWR, ST_DCAP, ST_DMW, ST_DONE
  } st_e;

  // control half-word field positions
  function automatic ctl_t ctl_decode(input logic [15:0] c);
    ctl_t r;
    r.cmd     = xfer_cmd_e'(c[1:0]);
    r.chain   = c[2];
    r.irq     = c[3];
    r.dec_sem = c[6];
    r.pio_n   = c[15:12];
    return r;
  endfunction

  // byte count to whole 32-bit words, rounded up
  function automatic logic [CNT_W-1:0] words_of(input logic [CNT_W-1:0] n);
    logic [CNT_W:0] t;
    t = {1'b0, n} + (CNT_W+1)'(3);
    return {1'b0, t[CNT_W:2]};
  endfunction

  function automatic logic moves_data(input ctl_t c, input logic [CNT_W-1:0] w);
    return (w != '0) && (c.cmd == CMD_DEV2MEM || c.cmd == CMD_MEM2DEV);
  endfunction
endpackage

// File: rtl/dce_sem.sv
module dce_sem #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         add_en,
  input  logic [W-1:0] add_val,
  input  logic         dec_en,
  output logic [W-1:0] count,
  output logic [W-1:0] count_nxt
);
  assign count_nxt = count + (add_en ? add_val : '0) - W'(dec_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end
endmodule

// File: rtl/dce_bus_gate.sv
module dce_bus_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic hold,
  input  logic ack,
  output logic req
);
  logic issued;

  // a request already on the bus stays until answered; new ones wait for !hold
  assign req = want && (issued || !hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) issued <= 1'b0;
    else        issued <= req && !ack;
  end
endmodule

// File: rtl/desc_chain_engine.sv
module desc_chain_engine
  import dce_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SEM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_addr_we,
  input  logic [AW-1:0]     desc_addr_wdata,
  input  logic              sem_add_we,
  input  logic [SEM_W-1:0]  sem_add_val,
  input  logic              freeze,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_err,
  output logic              pio_we,
  output logic [PIO_W-1:0]  pio_idx,
  output logic [WORD_W-1:0] pio_wdata,
  output logic              dev_wr,
  output logic [WORD_W-1:0] dev_wdata,
  output logic              dev_rd,
  input  logic [WORD_W-1:0] dev_rdata,
  output logic              cmpl_pulse,
  output logic              err_pulse,
  output logic [1:0]        err_code,
  output logic              busy,
  output logic [SEM_W-1:0]  sem_count,
  output logic [AW-1:0]     buf_addr,
  output logic [AW-1:0]     cur_desc
);
  localparam logic [AW-1:0] STEP = AW'(4);

  st_e               st;
  ctl_t              ctl_q;
  logic [AW-1:0]     cur_q, next_q, bar_q;
  logic [CNT_W-1:0]  wl_q;
  logic [WORD_W-1:0] data_q;
  logic [PIO_W-1:0]  pio_k;
  logic              armed_q;
  logic [SEM_W-1:0]  sem_q, sem_nxt;

  // named internal events
  logic mem_want, beat_ok, beat_bad, desc_done, last_pio, last_word;
  st_e  data_st;

  assign mem_want  = st inside {ST_NEXT, ST_CTRL, ST_BUF, ST_PRD, ST_DRD, ST_DMW};
  assign beat_ok   = mem_req && mem_ack && !mem_err;
  assign beat_bad  = mem_req && mem_ack && mem_err;
  assign desc_done = (st == ST_DONE);
  assign last_pio  = ({1'b0, pio_k} + 5'd1) == {1'b0, ctl_q.pio_n};
  assign last_word = (wl_q == CNT_W'(1));

  always_comb begin
    if (!moves_data(ctl_q, wl_q))        data_st = ST_DONE;
    else if (ctl_q.cmd == CMD_MEM2DEV)   data_st = ST_DRD;
    else                                 data_st = ST_DCAP;
  end

  dce_bus_gate u_gate (
    .clk(clk), .rst_n(rst_n), .want(mem_want), .hold(freeze),
    .ack(mem_ack), .req(mem_req)
  );

  dce_sem #(.W(SEM_W)) u_sem (
    .clk(clk), .rst_n(rst_n), .add_en(sem_add_we), .add_val(sem_add_val),
    .dec_en(desc_done && ctl_q.dec_sem), .count(sem_q), .count_nxt(sem_nxt)
  );

  always_comb begin
    case (st)
      ST_CTRL:         mem_addr = cur_q + STEP;
      ST_BUF:          mem_addr = cur_q + AW'(8);
      ST_PRD:          mem_addr = cur_q + AW'(12) + AW'({pio_k, 2'b00});
      ST_DRD, ST_DMW:  mem_addr = bar_q;
      default:         mem_addr = cur_q;
    endcase
  end

  assign mem_we     = (st == ST_DMW);
  assign mem_wdata  = data_q;
  assign pio_we     = (st == ST_PWR) && !freeze;
  assign pio_idx    = pio_k;
  assign pio_wdata  = data_q;
  assign dev_wr     = (st == ST_DWR) && !freeze;
  assign dev_wdata  = data_q;
  assign dev_rd     = (st == ST_DCAP) && !freeze;
  assign cmpl_pulse = desc_done && ctl_q.irq;
  assign err_pulse  = beat_bad;
  assign err_code   = beat_bad ? ERR_BUS : 2'b00;
  assign busy       = (st != ST_IDLE);
  assign sem_count  = sem_q;
  assign buf_addr   = bar_q;
  assign cur_desc   = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ctl_q   <= '0;
      cur_q   <= '0;
      next_q  <= '0;
      bar_q   <= '0;
      wl_q    <= '0;
      data_q  <= '0;
      pio_k   <= '0;
      armed_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (desc_addr_we) begin
            cur_q   <= desc_addr_wdata;
            armed_q <= 1'b1;
          end else if (armed_q && sem_q != '0 && !freeze) begin
            st <= ST_NEXT;
          end
        end
        ST_NEXT: if (beat_ok) begin
          next_q <= AW'(mem_rdata);
          st     <= ST_CTRL;
        end
        ST_CTRL: if (beat_ok) begin
          ctl_q <= ctl_decode(mem_rdata[15:0]);
          wl_q  <= words_of(mem_rdata[31:16]);
          st    <= ST_BUF;
        end
        ST_BUF: if (beat_ok) begin
          bar_q <= AW'(mem_rdata);
          pio_k <= '0;
          st    <= (ctl_q.pio_n != '0) ? ST_PRD : data_st;
        end
        ST_PRD: if (beat_ok) begin
          data_q <= mem_rdata;
          st     <= ST_PWR;
        end
        ST_PWR: if (!freeze) begin
          pio_k <= pio_k + 1'b1;
          st    <= last_pio ? data_st : ST_PRD;
        end
        ST_DRD: if (beat_ok) begin
          data_q <= mem_rdata;
          st     <= ST_DWR;
        end
        ST_DWR: if (!freeze) begin
          bar_q <= bar_q + STEP;
          wl_q  <= wl_q - 1'b1;
          st    <= last_word ? ST_DONE : ST_DRD;
        end
        ST_DCAP: if (!freeze) begin
          data_q <= dev_rdata;
          st     <= ST_DMW;
        end
        ST_DMW: if (beat_ok) begin
          bar_q <= bar_q + STEP;
          wl_q  <= wl_q - 1'b1;
          st    <= last_word ? ST_DONE : ST_DCAP;
        end
        ST_DONE: begin
          if (ctl_q.chain) begin
            cur_q <= next_q;
            st    <= (sem_nxt != '0) ? ST_NEXT : ST_IDLE;
          end else begin
            st      <= ST_IDLE;
            armed_q <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (beat_bad) begin
        st      <= ST_IDLE;
        armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dce_checker.sv
module dce_checker #(
  parameter int AW = 32,
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          freeze,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          pio_we,
  input logic          dev_wr,
  input logic          dev_rd,
  input logic          cmpl_pulse,
  input logic          err_pulse,
  input logic [1:0]    err_code,
  input logic          busy,
  input logic          sem_add_we,
  input logic [SW-1:0] sem_count,
  input logic [AW-1:0] buf_addr,
  input logic          desc_done
);
  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pio_we, dev_wr, dev_rd}));

  assert_freeze_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !(pio_we || dev_wr || dev_rd));

  assert_freeze_noreq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !mem_req) |=> (!freeze || !mem_req));

  assert_bar_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !(mem_req && mem_ack)) |=> $stable(buf_addr));

  assert_cmpl_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_pulse |=> !cmpl_pulse);

  assert_cmpl_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_pulse |-> desc_done);

  assert_err_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_code == 2'b10 && !cmpl_pulse));

  assert_err_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !busy);

  assert_sem_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sem_add_we |=> (sem_count == $past(sem_count) ||
                     sem_count == $past(sem_count) - SW'(1)));
endmodule

bind desc_chain_engine dce_checker #(.AW(AW), .SW(SEM_W)) u_dce_checker (
  .clk(clk), .rst_n(rst_n), .freeze(freeze), .mem_req(mem_req),
  .mem_ack(mem_ack), .pio_we(pio_we), .dev_wr(dev_wr), .dev_rd(dev_rd),
  .cmpl_pulse(cmpl_pulse), .err_pulse(err_pulse), .err_code(err_code),
  .busy(busy), .sem_add_we(sem_add_we), .sem_count(sem_count),
  .buf_addr(buf_addr), .desc_done(desc_done)
);

// File: tb/tb_desc_chain_engine.sv
`timescale 1ns/1ps
module tb_desc_chain_engine;
  localparam int AW = 32;
  localparam int SW = 8;
  localparam logic [31:0] ERR_BASE = 32'h8000_0000;
  localparam logic [31:0] DEV_BASE = 32'hC0DE_0000;
  localparam logic [15:0] C_M2D = 16'h0002, C_D2M = 16'h0001, C_SNS = 16'h0003;
  localparam logic [15:0] C_CHN = 16'h0004, C_IRQ = 16'h0008, C_DEC = 16'h0040;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, desc_addr_we, sem_add_we, freeze;
  logic [AW-1:0] desc_addr_wdata;
  logic [SW-1:0] sem_add_val;
  logic mem_req, mem_we, mem_ack, mem_err;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic pio_we, dev_wr, dev_rd, cmpl_pulse, err_pulse, busy;
  logic [3:0] pio_idx;
  logic [31:0] pio_wdata, dev_wdata, dev_rdata;
  logic [1:0] err_code;
  logic [SW-1:0] sem_count;
  logic [AW-1:0] buf_addr, cur_desc;

  desc_chain_engine #(.AW(AW), .SEM_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .desc_addr_we(desc_addr_we),
    .desc_addr_wdata(desc_addr_wdata), .sem_add_we(sem_add_we),
    .sem_add_val(sem_add_val), .freeze(freeze), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .pio_we(pio_we), .pio_idx(pio_idx), .pio_wdata(pio_wdata),
    .dev_wr(dev_wr), .dev_wdata(dev_wdata), .dev_rd(dev_rd),
    .dev_rdata(dev_rdata), .cmpl_pulse(cmpl_pulse), .err_pulse(err_pulse),
    .err_code(err_code), .busy(busy), .sem_count(sem_count),
    .buf_addr(buf_addr), .cur_desc(cur_desc)
  );

  int errors = 0;
  int checks = 0;
  logic [67:0] exp_q[$];
  logic [31:0] mem[int];
  int dev_n = 0;
  int model_dev = 0;
  bit dev_pend = 1'b0;
  int lat = 0;
  int sem_model = 0;

  function automatic logic [31:0] memrd(input logic [31:0] a);
    if (mem.exists(int'(a >> 2))) return mem[int'(a >> 2)];
    return {a[15:0], ~a[15:0]};
  endfunction

  function automatic int lat_of(input logic [31:0] a);
    return int'(a[3:2]) % 3;
  endfunction

  function automatic string tag_of(input logic [3:0] k);
    case (k)
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic observe(input logic [3:0] k, input logic [31:0] a, input logic [31:0] d);
    logic [67:0] ev;
    logic [67:0] e;
    ev = {k, a, d};
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL %s actual=%h expected=none", tag_of(k), ev);
    end else begin
      e = exp_q.pop_front();
      if (e !== ev) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", tag_of(k), ev, e);
      end
    end
  endtask

  // memory responder, device source and event monitor, compared every clock
  always @(negedge clk) begin
    if (dev_pend) begin dev_n++; dev_pend = 1'b0; end
    dev_rdata = DEV_BASE + 32'(dev_n);
    if (mem_ack) begin
      mem_ack = 1'b0; mem_err = 1'b0; lat = 0;
    end else if (mem_req && rst_n) begin
      if (lat >= lat_of(mem_addr)) begin
        mem_ack = 1'b1; lat = 0;
        if (mem_addr >= ERR_BASE) begin
          mem_err = 1'b1; mem_rdata = '0;
        end else if (mem_we) begin
          mem[int'(mem_addr >> 2)] = mem_wdata;
          observe(4'd3, mem_addr, mem_wdata);
        end else begin
          mem_rdata = memrd(mem_addr);
        end
      end else lat++;
    end
    #1;
    if (rst_n) begin
      if (freeze && (pio_we || dev_wr || dev_rd))
        chk(1'b0, "R12", {29'b0, pio_we, dev_wr, dev_rd}, 32'h0);
      if (pio_we)     observe(4'd1, {28'b0, pio_idx}, pio_wdata);
      if (dev_wr)     observe(4'd2, buf_addr, dev_wdata);
      if (dev_rd)     dev_pend = 1'b1;
      if (cmpl_pulse) observe(4'd4, 32'h0, 32'h0);
      if (err_pulse)  observe(4'd5, 32'h0, {30'b0, err_code});
    end
  end

  // behavioural expectation of one run from a start descriptor
  task automatic model_run(input logic [31:0] start);
    logic [31:0] d, nx, w1, bf, a;
    logic [15:0] ctl, cnt;
    int nw;
    d = start;
    forever begin
      nx  = memrd(d);
      w1  = memrd(d + 4);
      bf  = memrd(d + 8);
      ctl = w1[15:0];
      cnt = w1[31:16];
      nw  = (int'(cnt) + 3) / 4;
      for (int k = 0; k < int'(ctl[15:12]); k++)
        exp_q.push_back({4'd1, 32'(k), memrd(d + 12 + 32'(4 * k))});
      if (ctl[1:0] == 2'd2 || ctl[1:0] == 2'd1) begin
        for (int i = 0; i < nw; i++) begin
          a = bf + 32'(4 * i);
          if (a >= ERR_BASE) begin
            exp_q.push_back({4'd5, 32'h0, 32'h2});
            return;
          end
          if (ctl[1:0] == 2'd2) exp_q.push_back({4'd2, a, memrd(a)});
          else begin
            exp_q.push_back({4'd3, a, DEV_BASE + 32'(model_dev)});
            model_dev++;
          end
        end
      end
      if (ctl[3]) exp_q.push_back({4'd4, 32'h0, 32'h0});
      if (ctl[6]) sem_model--;
      if (!ctl[2] || sem_model == 0) return;
      d = nx;
    end
  endtask

  task automatic put_desc(input logic [31:0] b, input logic [31:0] nx, input logic [15:0] ctl,
                          input logic [15:0] cnt, input logic [31:0] bf);
    mem[int'(b >> 2)]     = nx;
    mem[int'(b >> 2) + 1] = {cnt, ctl};
    mem[int'(b >> 2) + 2] = bf;
    for (int k = 0; k < int'(ctl[15:12]); k++)
      mem[int'(b >> 2) + 3 + k] = 32'hB000_0000 | (b + 32'(k));
  endtask

  task automatic wr_addr(input logic [31:0] a);
    @(negedge clk); desc_addr_we = 1'b1; desc_addr_wdata = a;
    @(negedge clk); desc_addr_we = 1'b0;
  endtask

  task automatic add_sem(input int v);
    @(negedge clk); sem_add_we = 1'b1; sem_add_val = SW'(v);
    @(negedge clk); sem_add_we = 1'b0;
    sem_model += v;
  endtask

  task automatic wait_idle(input string req);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 150000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, req, 32'(exp_q.size()), 32'h0);
    chk(busy == 1'b0, req, {31'b0, busy}, 32'h0);
    chk(sem_count == SW'(sem_model), req, 32'(sem_count), 32'(sem_model));
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] b;
    rst_n = 1'b0; desc_addr_we = 1'b0; desc_addr_wdata = '0; sem_add_we = 1'b0;
    sem_add_val = '0; freeze = 1'b0; mem_ack = 1'b0; mem_err = 1'b0;
    mem_rdata = '0; dev_rdata = DEV_BASE;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_req && !pio_we && !dev_wr && !dev_rd && !cmpl_pulse && !err_pulse,
        "R1", {25'b0, busy, mem_req, pio_we, dev_wr, dev_rd, cmpl_pulse, err_pulse}, 32'h0);
    chk(sem_count == '0, "R1", 32'(sem_count), 32'h0);
    chk(buf_addr == '0, "R1", buf_addr, 32'h0);
    rst_n = 1'b1;

    // R3 R4 R13: one descriptor, 3 register words, 10 bytes to device
    put_desc(32'h100, 32'h0, C_M2D | C_IRQ | C_DEC | 16'h3000, 16'd10, 32'h1000);
    wr_addr(32'h100);
    repeat (5) @(negedge clk);
    chk(!busy, "R2", {31'b0, busy}, 32'h0);
    add_sem(1);
    model_run(32'h100);
    wait_idle("R4");
    chk(buf_addr == 32'h100C, "R13", buf_addr, 32'h100C);

    // R9: unchained end needs a new start address
    add_sem(1);
    repeat (20) @(negedge clk);
    chk(!busy, "R9", {31'b0, busy}, 32'h0);
    chk(sem_count == 8'd1, "R9", 32'(sem_count), 32'h1);
    wr_addr(32'h100);
    model_run(32'h100);
    wait_idle("R9");

    // R5 R8: device-to-memory chained to a register-only descriptor
    put_desc(32'h200, 32'h240, C_D2M | C_CHN, 16'd8, 32'h2000);
    put_desc(32'h240, 32'h0, 16'h2000 | C_IRQ | C_DEC, 16'd100, 32'h3000);
    wr_addr(32'h200);
    add_sem(1);
    model_run(32'h200);
    wait_idle("R5");
    chk(memrd(32'h2004) == DEV_BASE + 1, "R5", memrd(32'h2004), DEV_BASE + 1);
    chk(buf_addr == 32'h3000, "R6", buf_addr, 32'h3000);

    // R6: zero count then sense command, no data
    put_desc(32'h600, 32'h640, C_M2D | C_CHN, 16'd0, 32'h5800);
    put_desc(32'h640, 32'h0, C_SNS | C_IRQ | C_DEC, 16'd8, 32'h6000);
    wr_addr(32'h600);
    add_sem(1);
    model_run(32'h600);
    wait_idle("R6");
    chk(buf_addr == 32'h6000, "R6", buf_addr, 32'h6000);

    // R7 R8: ring of two paced by credit
    put_desc(32'h400, 32'h440, C_M2D | C_CHN | C_IRQ | C_DEC, 16'd4, 32'h4000);
    put_desc(32'h440, 32'h400, C_M2D | C_CHN | C_IRQ | C_DEC, 16'd4, 32'h4100);
    wr_addr(32'h400);
    add_sem(2);
    model_run(32'h400);
    wait_idle("R7");
    chk(cur_desc == 32'h400, "R8", cur_desc, 32'h400);
    add_sem(1);
    model_run(32'h400);
    wait_idle("R8");
    chk(cur_desc == 32'h440, "R8", cur_desc, 32'h440);

    // R12: freeze in the middle of the data phase
    put_desc(32'h500, 32'h0, C_M2D | C_IRQ | C_DEC | 16'h1000, 16'd64, 32'h5000);
    wr_addr(32'h500);
    add_sem(1);
    model_run(32'h500);
    repeat (18) @(negedge clk);
    freeze = 1'b1;
    repeat (4) @(negedge clk);
    b = buf_addr;
    repeat (16) @(negedge clk);
    chk(buf_addr == b, "R12", buf_addr, b);
    chk(busy, "R12", {31'b0, busy}, 32'h1);
    freeze = 1'b0;
    wait_idle("R12");
    chk(buf_addr == 32'h5040, "R13", buf_addr, 32'h5040);

    // R11: error response aborts, credit kept, restart needs address
    put_desc(32'h700, 32'h0, C_M2D | C_IRQ | C_DEC, 16'd8, ERR_BASE);
    wr_addr(32'h700);
    add_sem(1);
    model_run(32'h700);
    wait_idle("R11");
    repeat (20) @(negedge clk);
    chk(!busy && sem_count == 8'd1, "R11", {busy, 23'b0, sem_count}, 32'h1);

    // R13: largest byte count, addresses traced through buf_addr
    put_desc(32'h800, 32'h0, C_M2D | C_IRQ | C_DEC, 16'hFF00, 32'h10000);
    wr_addr(32'h800);
    model_run(32'h800);
    wait_idle("R13");
    chk(buf_addr == 32'h1FF00, "R13", buf_addr, 32'h1FF00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule